// File: doc/BRIEF.md
# VGA Raster Timing Generator

This block produces the raster timing for a 640x480 display at roughly 60 frames per second. It runs from a 100 MHz system clock. An internal divider raises a pixel enable on one clock in every four, which gives a 25 MHz pixel rate. On each pixel enable a column counter advances. When the column is at its final value, a row counter advances as well.

The block decodes the two counters into five signals. Both sync outputs are active low. The two end-of-visible flags are combinational. The blanking flag lets downstream colour logic force black outside the visible area. Colour generation and the output registers that remove glitches belong to the parent design. All porch and pulse lengths are parameters, and the divide ratio is also a parameter. The defaults give 800 columns by 521 lines.

Top module: `vgaTiming`

## Requirements
- R1: The pixel enable is high for one system clock in every four. After synchronous reset is released, the column first advances on the fourth rising edge and then on every fourth edge after that.
- R2: The column counter counts 0 to 799 and wraps to 0. It changes only on a pixel enable.
- R3: `hSyncN` is 0 exactly while the column is in 656..751, which is 96 columns or 384 system clocks. It is 1 on every other column.
- R4: The row counter advances only when the column is 799 and the pixel enable is high. It counts 0 to 520 and wraps to 0.
- R5: `vSyncN` is 0 exactly while the row is in 490..491, which is two full lines. It is 1 on every other row.
- R6: `lastCol` is 1 in the same cycle that the column equals 639 and 0 otherwise. `lastRow` is 1 in the same cycle that the row equals 479 and 0 otherwise.
- R7: `blank` is 1 when the column is above 639 or the row is above 479. It is 0 otherwise.
- R8: While `rst` is 1 at a rising edge, the divider, the column and the row are cleared to 0.
- R9: The sync pattern repeats every 800 x 521 x 4 = 1,667,200 system clocks. In general the period is the column total times the row total times the divide ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (four times the pixel rate) |
| rst | input | 1 | Synchronous reset, active high |
| hSyncN | output | 1 | Horizontal sync, active low |
| vSyncN | output | 1 | Vertical sync, active low |
| pixelCol | output | 10 | Current column |
| pixelRow | output | 10 | Current row |
| lastCol | output | 1 | Column is the final visible one |
| lastRow | output | 1 | Row is the final visible one |
| blank | output | 1 | Current position lies outside the visible area |

## Verification
The bench goes after the edges of each phase: 639/640, 655/656, 751/752 and the 799 wrap on the columns, and 479/480, 489/490, 491/492 and the 520 wrap on the rows. An off-by-one compare moves a sync edge by one pixel. That shows up as a pulse 4 clocks too long or too short, or as a frame period that is wrong by a line or by a pixel.

A divider that fires on the wrong count, or that is not cleared by reset, shifts every column update by up to three clocks. Resets are injected at random points, including mid-line, to expose any counter that survives reset. Full frames take too long at the default size, so a second instance with small porches checks the row boundaries, the 2-line vertical pulse and the frame period within the cycle budget.

// File: rtl/vgaTimingPkg.sv
package vgaTimingPkg;
  // Strobes passed from the sequencing control to the counter datapath.
  typedef struct packed {
    logic pixelEn;   // one system clock per pixel
    logic colClear;  // column at its final value on a pixel step
    logic rowStep;   // advance row this cycle
    logic rowClear;  // row at its final value on a row step
  } stepStrobes_t;
endpackage

// File: rtl/vgaTimingCtrl.sv
module vgaTimingCtrl
  import vgaTimingPkg::*;
#(
  parameter int DIV = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         colAtEnd,
  input  logic         rowAtEnd,
  output stepStrobes_t strb
);
  localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(DIV - 1);

  logic [DW-1:0] divCnt;

  always_ff @(posedge clk) begin
    if (rst || divCnt == DIV_LAST) divCnt <= '0;
    else                           divCnt <= divCnt + 1'b1;
  end

  always_comb begin
    strb.pixelEn  = (divCnt == DIV_LAST);
    strb.colClear = strb.pixelEn && colAtEnd;
    strb.rowStep  = strb.colClear;
    strb.rowClear = strb.colClear && rowAtEnd;
  end

  // R1: enable never fires on two consecutive clocks
  p_enable_gap_r1: assert property (@(posedge clk) disable iff (rst)
    strb.pixelEn |=> !strb.pixelEn);

  // R1: once the enable fires, the following clock starts a new count
  p_enable_restart_r1: assert property (@(posedge clk) disable iff (rst)
    strb.pixelEn |=> divCnt == '0);
endmodule

// File: rtl/vgaTimingDatapath.sv
module vgaTimingDatapath
  import vgaTimingPkg::*;
#(
  parameter int CW      = 10,
  parameter int H_VIS   = 640,
  parameter int H_FRONT = 16,
  parameter int H_SYNC  = 96,
  parameter int H_BACK  = 48,
  parameter int V_VIS   = 480,
  parameter int V_FRONT = 10,
  parameter int V_SYNC  = 2,
  parameter int V_BACK  = 29
) (
  input  logic          clk,
  input  logic          rst,
  input  stepStrobes_t  strb,
  output logic [CW-1:0] col,
  output logic [CW-1:0] row,
  output logic          hSyncN,
  output logic          vSyncN,
  output logic          lastCol,
  output logic          lastRow,
  output logic          blank,
  output logic          colAtEnd,
  output logic          rowAtEnd
);
  localparam int H_TOTAL = H_VIS + H_FRONT + H_SYNC + H_BACK;
  localparam int V_TOTAL = V_VIS + V_FRONT + V_SYNC + V_BACK;
  localparam logic [CW-1:0] COL_END  = CW'(H_TOTAL - 1);
  localparam logic [CW-1:0] ROW_END  = CW'(V_TOTAL - 1);
  localparam logic [CW-1:0] COL_VLST = CW'(H_VIS - 1);
  localparam logic [CW-1:0] ROW_VLST = CW'(V_VIS - 1);
  localparam logic [CW-1:0] HS_LO    = CW'(H_VIS + H_FRONT);
  localparam logic [CW-1:0] HS_HI    = CW'(H_VIS + H_FRONT + H_SYNC);
  localparam logic [CW-1:0] VS_LO    = CW'(V_VIS + V_FRONT);
  localparam logic [CW-1:0] VS_HI    = CW'(V_VIS + V_FRONT + V_SYNC);

  always_ff @(posedge clk) begin
    if (rst)                col <= '0;
    else if (strb.colClear) col <= '0;
    else if (strb.pixelEn)  col <= col + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                row <= '0;
    else if (strb.rowClear) row <= '0;
    else if (strb.rowStep)  row <= row + 1'b1;
  end

  always_comb begin
    colAtEnd = (col == COL_END);
    rowAtEnd = (row == ROW_END);
    lastCol  = (col == COL_VLST);
    lastRow  = (row == ROW_VLST);
    hSyncN   = !((col >= HS_LO) && (col < HS_HI));
    vSyncN   = !((row >= VS_LO) && (row < VS_HI));
    blank    = (col > COL_VLST) || (row > ROW_VLST);
  end

  // R2: column holds between pixel enables
  p_col_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !strb.pixelEn |=> $stable(col));
  // R2: column wraps after its final value
  p_col_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (strb.pixelEn && colAtEnd) |=> col == '0);
  // R4: row moves only on a row step
  p_row_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !strb.rowStep |=> $stable(row));
  // R3 R5 R7: sync pulses lie inside the blanking interval
  p_hsync_blank_r3: assert property (@(posedge clk) disable iff (rst)
    !hSyncN |-> blank);
  p_vsync_blank_r5: assert property (@(posedge clk) disable iff (rst)
    !vSyncN |-> blank);
  // R6: the final visible pixel is never blanked
  p_flags_visible_r6: assert property (@(posedge clk) disable iff (rst)
    (lastCol && lastRow) |-> !blank);
  // R8: reset clears both counters
  p_reset_clears_r8: assert property (@(posedge clk)
    rst |=> (col == '0 && row == '0));
endmodule

// File: rtl/vgaTiming.sv
module vgaTiming
  import vgaTimingPkg::*;
#(
  parameter int CW      = 10,
  parameter int DIV     = 4,
  parameter int H_VIS   = 640,
  parameter int H_FRONT = 16,
  parameter int H_SYNC  = 96,
  parameter int H_BACK  = 48,
  parameter int V_VIS   = 480,
  parameter int V_FRONT = 10,
  parameter int V_SYNC  = 2,
  parameter int V_BACK  = 29
) (
  input  logic          clk,
  input  logic          rst,
  output logic          hSyncN,
  output logic          vSyncN,
  output logic [CW-1:0] pixelCol,
  output logic [CW-1:0] pixelRow,
  output logic          lastCol,
  output logic          lastRow,
  output logic          blank
);
  stepStrobes_t strb;
  logic colAtEnd;
  logic rowAtEnd;

  vgaTimingCtrl #(.DIV(DIV)) ctrl_i (
    .clk(clk), .rst(rst), .colAtEnd(colAtEnd), .rowAtEnd(rowAtEnd), .strb(strb)
  );

  vgaTimingDatapath #(
    .CW(CW), .H_VIS(H_VIS), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC), .H_BACK(H_BACK),
    .V_VIS(V_VIS), .V_FRONT(V_FRONT), .V_SYNC(V_SYNC), .V_BACK(V_BACK)
  ) dp_i (
    .clk(clk), .rst(rst), .strb(strb),
    .col(pixelCol), .row(pixelRow), .hSyncN(hSyncN), .vSyncN(vSyncN),
    .lastCol(lastCol), .lastRow(lastRow), .blank(blank),
    .colAtEnd(colAtEnd), .rowAtEnd(rowAtEnd)
  );
endmodule

// File: tb/vgaTiming_tb_top.sv
`timescale 1ns/1ps
module vgaTiming_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  bit checking = 1'b0;

  // default-size instance
  logic hsA, vsA, lcA, lrA, blA;
  logic [9:0] colA, rowA;
  vgaTiming dut_i (
    .clk(clk), .rst(rst), .hSyncN(hsA), .vSyncN(vsA), .pixelCol(colA),
    .pixelRow(rowA), .lastCol(lcA), .lastRow(lrA), .blank(blA)
  );

  // small instance: 25 columns x 13 rows, frame = 1300 clocks
  logic hsS, vsS, lcS, lrS, blS;
  logic [9:0] colS, rowS;
  vgaTiming #(.H_VIS(16), .H_FRONT(2), .H_SYNC(4), .H_BACK(3),
              .V_VIS(6), .V_FRONT(2), .V_SYNC(2), .V_BACK(3)) dut_small_i (
    .clk(clk), .rst(rst), .hSyncN(hsS), .vSyncN(vsS), .pixelCol(colS),
    .pixelRow(rowS), .lastCol(lcS), .lastRow(lrS), .blank(blS)
  );

  // edges since reset release: the bench's own position reference
  int n = 0;
  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) n <= 0; else n <= n + 1;
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic checkInst(string tag, int col, int row, logic hs, logic vs,
                           logic lc, logic lr, logic bl,
                           int hv, int hf, int hsw, int hb,
                           int vv, int vf, int vsw, int vb);
    int ht, vt, p, ec, er;
    ht = hv + hf + hsw + hb;
    vt = vv + vf + vsw + vb;
    p  = n / 4;                         // R1 one pixel per four clocks
    ec = p % ht;                        // R2
    er = (p / ht) % vt;                 // R4
    chk({"R1/R2 ", tag}, "col", col, ec);
    chk({"R4 ", tag}, "row", row, er);
    chk({"R3 ", tag}, "hSyncN", int'(hs), int'(!(ec >= hv + hf && ec < hv + hf + hsw)));
    chk({"R5 ", tag}, "vSyncN", int'(vs), int'(!(er >= vv + vf && er < vv + vf + vsw)));
    chk({"R6 ", tag}, "lastCol", int'(lc), int'(ec == hv - 1));
    chk({"R6 ", tag}, "lastRow", int'(lr), int'(er == vv - 1));
    chk({"R7 ", tag}, "blank", int'(bl), int'(ec > hv - 1 || er > vv - 1));
  endtask

  // per-cycle comparison against the reference, sampled at falling edges
  logic prevHs = 1'b1, prevVs = 1'b1;
  bit hMeas = 1'b0, vMeas = 1'b0, haveFall = 1'b0;
  int hRun = 0, vRun = 0, lastFall = 0;
  always @(negedge clk) begin
    if (checking) begin
      if (rst) begin
        if (n == 0 && cyc > 1) begin  // R8 counters cleared under reset
          chk("R8", "col", int'(colA), 0);
          chk("R8", "row", int'(rowA), 0);
          chk("R8", "small col", int'(colS), 0);
        end
        hMeas = 1'b0; vMeas = 1'b0; haveFall = 1'b0;
      end else begin
        checkInst("default", int'(colA), int'(rowA), hsA, vsA, lcA, lrA, blA,
                  640, 16, 96, 48, 480, 10, 2, 29);
        checkInst("small", int'(colS), int'(rowS), hsS, vsS, lcS, lrS, blS,
                  16, 2, 4, 3, 6, 2, 2, 3);
        // R3 horizontal pulse width in system clocks
        if (prevHs && !hsA) begin hMeas = 1'b1; hRun = 1; end
        else if (!hsA && hMeas) hRun++;
        else if (hsA && !prevHs && hMeas) begin
          chk("R3", "hsync low clocks", hRun, 384);
          hMeas = 1'b0;
        end
        // R5 vertical pulse width, R9 frame period (small instance)
        if (prevVs && !vsS) begin
          if (haveFall) chk("R9", "frame clocks", cyc - lastFall, 1300);
          haveFall = 1'b1; lastFall = cyc; vMeas = 1'b1; vRun = 1;
        end else if (!vsS && vMeas) vRun++;
        else if (vsS && !prevVs && vMeas) begin
          chk("R5", "vsync low clocks", vRun, 2 * 25 * 4);
          vMeas = 1'b0;
        end
      end
    end
    prevHs = rst ? 1'b1 : hsA;
    prevVs = rst ? 1'b1 : vsS;
  end

  task automatic runClocks(int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  initial begin
    void'($urandom(32'd5150));
    checking = 1'b1;
    runClocks(3);
    rst = 1'b0;
    // R1: column still 0 after three edges, 1 after the fourth
    runClocks(3);
    chk("R1", "col after 3 edges", int'(colA), 0);
    runClocks(1);
    chk("R1", "col after 4 edges", int'(colA), 1);
    runClocks(12000);                  // several full default lines
    // random reset points, including mid-line
    for (int i = 0; i < 6; i++) begin
      rst = 1'b1;
      runClocks($urandom_range(1, 4));
      rst = 1'b0;
      runClocks($urandom_range(500, 6000));
    end
    rst = 1'b1;
    runClocks(2);
    rst = 1'b0;
    runClocks(6000);                   // several small frames for R9
    done = 1'b1;
    checking = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule